// File: doc/BRIEF.md
# TDM frame sync generator

This block produces the frame timing for a time-division-multiplexed audio port. It runs in the bit-clock domain, so one clock cycle is one bit clock. It counts bit clocks into frames of programmable length and divides each frame into slots of programmable length and count. It drives strobes that mark the first bit of a frame and the first bit of each active slot, along with the index of the current slot. The serializers on either side use these strobes to place and collect words.

As timing master, the block drives a frame-sync line. The pulse is short (one bit clock, either late or early) or long (one slot wide). As follower, it keeps its sync output low and realigns its bit counter to the rising edge of an external sync. Software programs three registers through a write-enable, address and data port:

- address 0 is control: bit 0 enable, bit 1 follower, bit 2 long sync, bit 3 early.
- address 1 holds the frame divider.
- address 2 holds the slot length in bits 5:0 and the slot count in bits 9:6.

A frame lasts divider + 1 bit clocks. A configuration that cannot hold its slots is flagged and keeps the counters stopped.

Top module: `tdm_fsg_top`

## Requirements
- R1: While rst_ni is low, fsync_o, frame_start_o and slot_start_o are 0 and slot_idx_o is 0. cfg_err_o is 0, because the reset configuration (divider 63, slot length 16, slot count 2, control 0) is legal.
- R2: When running, a frame lasts divider + 1 bit clocks. frame_start_o is 1 in bit 0 of every frame and only there. Bit 0 is the first cycle after the clock edge that sets the enable bit (control bit 0).
- R3: Bit b of a frame belongs to slot b / slot length. slot_start_o is 1 when b mod slot length is 0 and the slot number is below the slot count. slot_idx_o shows the slot number, saturated at the slot count in the idle bits that follow the last slot.
- R4: Master with short late sync (control bits 1, 2 and 3 all 0): fsync_o is 1 only in bit 0 of each frame.
- R5: Master with short early sync (control bit 3 = 1, bit 2 = 0): fsync_o is 1 only in the last bit (bit = divider) of each frame.
- R6: Master with long sync (control bit 2 = 1): fsync_o is 1 for bits 0 to slot length - 1 of each frame. The early bit has no effect in this mode.
- R7: cfg_err_o is 1 when divider + 1 is below slot length × slot count, or when the slot length or the slot count is 0. Equality is legal.
- R8: In long sync mode with a slot count of 1 or less, cfg_err_o is also 1 when divider + 1 is not strictly greater than the slot length. Short mode allows equality.
- R9: While the enable bit is 0 or cfg_err_o is 1, the counters are held at zero: fsync_o, frame_start_o and slot_start_o are 0 and slot_idx_o is 0.
- R10: As follower (control bit 1 = 1), fsync_o stays 0. A rising edge on ext_sync_i sampled at a clock edge makes the next cycle bit 0 of a new frame. Holding ext_sync_i high does not realign again. Between edges the frame counter wraps at divider + 1.
- R11: As master, ext_sync_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bit clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 2 | register address: 0 control, 1 divider, 2 slot format |
| wr_data_i | input | DATA_W | register write data |
| ext_sync_i | input | 1 | external frame sync, used in follower mode |
| fsync_o | output | 1 | generated frame sync, master mode only |
| frame_start_o | output | 1 | first bit of a frame |
| slot_start_o | output | 1 | first bit of an active slot |
| slot_idx_o | output | SCNT_W | current slot number |
| cfg_err_o | output | 1 | illegal frame configuration |

## Verification
The frame timing is exercised with a frame that carries four idle bits after two slots, and with one that is exactly filled by three slots. The first separates slot-index saturation from wrap behaviour; the second exposes off-by-one errors at the frame boundary. Short late, short early and long sync are each run over several frames. In long mode the early bit is set on purpose, which shows that long mode ignores it.

In follower mode the bench checks a free run before any sync, then a rising edge in mid-frame, then a held-high level, then a second edge. Together these distinguish edge realignment from level realignment. Configuration checks sit exactly on the legality boundaries, where the short and long rules differ.

// File: rtl/tdm_fsg_pkg.sv
package tdm_fsg_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SLOT = 2'd2;

  // bit 0 enable is fixed by software; others packed above it
  typedef struct packed {
    logic early;
    logic sync_long;
    logic follower;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/tdm_fsg_regs.sv
module tdm_fsg_regs
  import tdm_fsg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 10,
  parameter int SLEN_W   = 6,
  parameter int SCNT_W   = 4,
  parameter int DIV_RST  = 63,
  parameter int SLEN_RST = 16,
  parameter int SCNT_RST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [SLEN_W-1:0] slen_o,
  output logic [SCNT_W-1:0] scnt_o,
  output logic              cfg_err_o
);
  localparam int PROD_W = SLEN_W + SCNT_W;
  localparam int CMP_W  = (DIV_W + 1 > PROD_W) ? DIV_W + 1 : PROD_W;

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [SLEN_W-1:0] slen_q;
  logic [SCNT_W-1:0] scnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      slen_q <= SLEN_W'(SLEN_RST);
      scnt_q <= SCNT_W'(SCNT_RST);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        ADDR_DIV:  div_q  <= wr_data_i[DIV_W-1:0];
        ADDR_SLOT: begin
          slen_q <= wr_data_i[SLEN_W-1:0];
          scnt_q <= wr_data_i[PROD_W-1:SLEN_W];
        end
        default: ;
      endcase
    end
  end

  logic [CMP_W-1:0] frame_len, need_len;
  logic             short_err, long_err;

  always_comb begin
    frame_len = CMP_W'(div_q) + CMP_W'(1);
    need_len  = CMP_W'(slen_q) * CMP_W'(scnt_q);
    short_err = (slen_q == '0) || (scnt_q == '0) || (frame_len < need_len);
    long_err  = ctrl_q.sync_long && (scnt_q <= SCNT_W'(1)) &&
                (frame_len <= CMP_W'(slen_q));
  end

  assign ctrl_o    = ctrl_q;
  assign div_o     = div_q;
  assign slen_o    = slen_q;
  assign scnt_o    = scnt_q;
  assign cfg_err_o = short_err || long_err;
endmodule

// File: rtl/tdm_fsg_counter.sv
module tdm_fsg_counter #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              follower_i,
  input  logic              ext_sync_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [SLEN_W-1:0] slen_i,
  input  logic [SCNT_W-1:0] scnt_i,
  output logic [DIV_W-1:0]  bit_cnt_o,
  output logic [SCNT_W-1:0] slot_idx_o,
  output logic              slot_start_o
);
  logic [DIV_W-1:0]  bit_cnt_q;
  logic [SLEN_W-1:0] slot_bit_q;
  logic [SCNT_W-1:0] slot_idx_q;
  logic              ext_prev_q;
  logic              ext_rise, wrap, restart, slot_end;

  assign ext_rise = follower_i && ext_sync_i && !ext_prev_q;
  // >= so a divider shrunk mid-frame still wraps promptly
  assign wrap     = bit_cnt_q >= div_i;
  assign restart  = !run_i || ext_rise || wrap;
  assign slot_end = slot_bit_q == slen_i - SLEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      slot_bit_q <= '0;
      slot_idx_q <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_prev_q <= ext_sync_i;
      if (restart) begin
        bit_cnt_q  <= '0;
        slot_bit_q <= '0;
        slot_idx_q <= '0;
      end else begin
        bit_cnt_q <= bit_cnt_q + DIV_W'(1);
        if (slot_end) begin
          slot_bit_q <= '0;
          if (slot_idx_q < scnt_i) slot_idx_q <= slot_idx_q + SCNT_W'(1);
        end else begin
          slot_bit_q <= slot_bit_q + SLEN_W'(1);
        end
      end
    end
  end

  assign bit_cnt_o    = bit_cnt_q;
  assign slot_idx_o   = run_i ? slot_idx_q : '0;
  assign slot_start_o = run_i && (slot_bit_q == '0) && (slot_idx_q < scnt_i);
endmodule

// File: rtl/tdm_fsg_sync.sv
module tdm_fsg_sync #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6
) (
  input  logic              run_i,
  input  logic              follower_i,
  input  logic              sync_long_i,
  input  logic              early_i,
  input  logic [DIV_W-1:0]  bit_cnt_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [SLEN_W-1:0] slen_i,
  output logic              fsync_o,
  output logic              frame_start_o
);
  assign frame_start_o = run_i && (bit_cnt_i == '0);

  always_comb begin
    fsync_o = 1'b0;
    if (run_i && !follower_i) begin
      if (sync_long_i)  fsync_o = bit_cnt_i < DIV_W'(slen_i);
      else if (early_i) fsync_o = bit_cnt_i == div_i;
      else              fsync_o = bit_cnt_i == '0;
    end
  end
endmodule

// File: rtl/tdm_fsg_top.sv
module tdm_fsg_top
  import tdm_fsg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ext_sync_i,
  output logic              fsync_o,
  output logic              frame_start_o,
  output logic              slot_start_o,
  output logic [SCNT_W-1:0] slot_idx_o,
  output logic              cfg_err_o
);
  ctrl_t             cfg_ctrl;
  logic [DIV_W-1:0]  cfg_div;
  logic [SLEN_W-1:0] cfg_slen;
  logic [SCNT_W-1:0] cfg_scnt;
  logic [DIV_W-1:0]  bit_cnt;
  logic              run;

  tdm_fsg_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ctrl_o(cfg_ctrl), .div_o(cfg_div), .slen_o(cfg_slen),
    .scnt_o(cfg_scnt), .cfg_err_o(cfg_err_o)
  );

  assign run = cfg_ctrl.enable && !cfg_err_o;

  tdm_fsg_counter #(
    .DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .follower_i(cfg_ctrl.follower), .ext_sync_i(ext_sync_i),
    .div_i(cfg_div), .slen_i(cfg_slen), .scnt_i(cfg_scnt),
    .bit_cnt_o(bit_cnt), .slot_idx_o(slot_idx_o), .slot_start_o(slot_start_o)
  );

  tdm_fsg_sync #(
    .DIV_W(DIV_W), .SLEN_W(SLEN_W)
  ) u_sync (
    .run_i(run), .follower_i(cfg_ctrl.follower),
    .sync_long_i(cfg_ctrl.sync_long), .early_i(cfg_ctrl.early),
    .bit_cnt_i(bit_cnt), .div_i(cfg_div), .slen_i(cfg_slen),
    .fsync_o(fsync_o), .frame_start_o(frame_start_o)
  );
endmodule

// File: rtl/tdm_fsg_chk.sv
module tdm_fsg_chk
  import tdm_fsg_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SCNT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              ext_sync_i,
  input logic              fsync_o,
  input logic              frame_start_o,
  input logic              slot_start_o,
  input logic [SCNT_W-1:0] slot_idx_o,
  input logic              cfg_err_o,
  input ctrl_t             ctrl_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [SCNT_W-1:0] scnt_i
);
  a_r2_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && div_i != '0 && !wr_en_i && !(ctrl_i.follower && ext_sync_i))
      |=> !frame_start_o);

  a_r3_first_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (slot_start_o && slot_idx_o == '0));

  a_r3_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_idx_o <= scnt_i);

  a_r4_late_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !ctrl_i.follower && !ctrl_i.sync_long && !ctrl_i.early)
      |-> fsync_o);

  a_r5_early_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_o && !ctrl_i.sync_long && ctrl_i.early && !wr_en_i) |=> frame_start_o);

  a_r6_long_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !ctrl_i.follower && ctrl_i.sync_long) |-> fsync_o);

  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!frame_start_o && !slot_start_o && !fsync_o && slot_idx_o == '0));

  a_r10_follower_no_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.follower |-> !fsync_o);
endmodule

bind tdm_fsg_top tdm_fsg_chk #(.DIV_W(DIV_W), .SCNT_W(SCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .ext_sync_i(ext_sync_i),
  .fsync_o(fsync_o), .frame_start_o(frame_start_o), .slot_start_o(slot_start_o),
  .slot_idx_o(slot_idx_o), .cfg_err_o(cfg_err_o),
  .ctrl_i(cfg_ctrl), .div_i(cfg_div), .scnt_i(cfg_scnt)
);

// File: tb/tdm_fsg_top_tb.sv
`timescale 1ns/1ps
module tdm_fsg_top_tb;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 10;
  localparam int SLEN_W = 6;
  localparam int SCNT_W = 4;
  localparam int WD_NS  = 400000;

  typedef struct {
    logic        fsync;
    logic        fs;
    logic        ss;
    int          idx;
    string       req;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [1:0]        wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              ext_sync_i = 1'b0;
  logic              fsync_o, frame_start_o, slot_start_o, cfg_err_o;
  logic [SCNT_W-1:0] slot_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t q[$];

  // bench-side view of the programmed configuration
  int g_div = 63, g_slen = 16, g_scnt = 2;
  bit g_long = 0, g_early = 0, g_slave = 0;

  always #2 clk_i = ~clk_i;

  tdm_fsg_top #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ext_sync_i(ext_sync_i), .fsync_o(fsync_o),
    .frame_start_o(frame_start_o), .slot_start_o(slot_start_o),
    .slot_idx_o(slot_idx_o), .cfg_err_o(cfg_err_o)
  );

  task automatic wr_now(input logic [1:0] a, input int d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = DATA_W'(d);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_now(a, d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_ctrl_now(input bit en, input bit fol, input bit lng, input bit erl);
    g_slave = fol; g_long = lng; g_early = erl;
    wr_now(2'd0, {28'd0, erl, lng, fol, en});
  endtask

  task automatic set_slot(input int slen, input int scnt);
    g_slen = slen; g_scnt = scnt;
    wr(2'd2, (scnt << SLEN_W) | slen);
  endtask

  task automatic set_div(input int d);
    g_div = d;
    wr(2'd1, d);
  endtask

  // driver: queue expected outputs for n cycles starting at frame bit offset k0
  task automatic seg(input int k0, input int n, input bit run, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int f, b;
      f = g_div + 1;
      b = (k0 + i) % f;
      e.req = req;
      if (!run) begin
        e.fsync = 0; e.fs = 0; e.ss = 0; e.idx = 0;
      end else begin
        e.fs  = (b == 0);
        e.idx = (b / g_slen < g_scnt) ? b / g_slen : g_scnt;
        e.ss  = (b % g_slen == 0) && (b / g_slen < g_scnt);
        if (g_slave)      e.fsync = 0;
        else if (g_long)  e.fsync = (b < g_slen);
        else if (g_early) e.fsync = (b == f - 1);
        else              e.fsync = (b == 0);
      end
      q.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b0;
    end
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // monitor: compare one queued item per cycle, away from the clock edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (fsync_o !== e.fsync || frame_start_o !== e.fs ||
            slot_start_o !== e.ss || int'(slot_idx_o) != e.idx) begin
          failures++;
          $display("FAIL %s got fsync=%0b fs=%0b ss=%0b idx=%0d exp fsync=%0b fs=%0b ss=%0b idx=%0d",
                   e.req, fsync_o, frame_start_o, slot_start_o, slot_idx_o,
                   e.fsync, e.fs, e.ss, e.idx);
        end
      end
    end
  end

  initial begin
    #(WD_NS);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 fsync", fsync_o, 0);
    chk("R1 frame_start", frame_start_o, 0);
    chk("R1 slot_start", slot_start_o, 0);
    chk("R1 slot_idx", slot_idx_o, 0);
    chk("R1 cfg_err", cfg_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // frame of 12 bits, two 4-bit slots, 4 idle bits
    set_div(11);
    set_slot(4, 2);
    set_ctrl_now(1, 0, 0, 0);
    seg(0, 7, 1, "R2/R4");
    ext_sync_i = 1'b1;            // R11 master ignores external sync
    seg(7, 5, 1, "R11");
    ext_sync_i = 1'b0;
    seg(12, 18, 1, "R3/R4");

    set_ctrl_now(0, 0, 0, 0);
    seg(0, 3, 0, "R9");

    set_ctrl_now(1, 0, 0, 1);
    seg(0, 30, 1, "R5");
    set_ctrl_now(0, 0, 0, 0);
    seg(0, 2, 0, "R9");

    // exactly filled frame, long sync with early bit set (ignored)
    set_slot(4, 3);
    set_ctrl_now(1, 0, 1, 1);
    seg(0, 30, 1, "R6");
    set_ctrl_now(0, 0, 0, 0);
    seg(0, 2, 0, "R9");

    // configuration legality
    set_div(7);
    chk("R7 overfull", cfg_err_o, 1);
    set_ctrl_now(1, 0, 0, 0);
    seg(0, 5, 0, "R9 held by cfg_err");
    set_ctrl_now(0, 0, 0, 0);
    seg(0, 1, 0, "R9");
    set_slot(4, 2);
    chk("R7 exact fit", cfg_err_o, 0);
    set_slot(0, 2);
    chk("R7 zero slot length", cfg_err_o, 1);
    set_slot(4, 0);
    chk("R7 zero slot count", cfg_err_o, 1);
    set_slot(8, 1);
    chk("R8 short equal ok", cfg_err_o, 0);
    g_long = 1;
    wr(2'd0, 4'b0100);
    chk("R8 long equal err", cfg_err_o, 1);
    set_div(8);
    chk("R8 long longer ok", cfg_err_o, 0);
    g_long = 0;
    wr(2'd0, 0);

    // follower mode
    set_div(11);
    set_slot(4, 2);
    set_ctrl_now(1, 1, 0, 0);
    seg(0, 5, 1, "R10 free run");
    ext_sync_i = 1'b1;
    seg(0, 6, 1, "R10 realign");
    ext_sync_i = 1'b0;
    seg(6, 4, 1, "R10 no level realign");
    ext_sync_i = 1'b1;
    seg(0, 14, 1, "R10 second edge");
    ext_sync_i = 1'b0;

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule